// File: doc/BRIEF.md
# Wide Accumulator Saturating Clamp

This unit narrows a wide fixed-point accumulator to a 16-bit result in each of eight parallel lanes. Every lane presents its 48-bit accumulator as three 16-bit slices: high (bits 47:16 of the value take in the high and middle slices), middle and low. One shared 2-bit mode code selects how the narrowing is done, and the whole unit is combinational. The accumulator is neither held nor updated here, and nothing is multiplied.

Three modes are offered. The signed-middle mode saturates the 32-bit signed value in bits 47:16 to the 16-bit signed range. The unsigned-middle mode starts from the same saturated value, then sends negatives to zero and positive overflow to all ones. The signed-low mode passes the low slice when the saturated value equals the raw middle slice, and otherwise emits the saturated value with its top bit inverted, so underflow reads 0x0000 and overflow reads 0xFFFF. A datapath uses the unit at the end of a multiply-accumulate step to write back one of these narrowed views.

Top module: `accum_clamp_array`

## Requirements
- R1: With mode 2'b00 (signed middle) and bits 47:16 of a lane, read as a signed 32-bit value V, inside -32768..+32767, the lane result equals the middle slice.
- R2: With mode 2'b00, V below -32768 gives 0x8000. This case is flagged when the high slice is negative and either not all ones or the middle slice's bit 15 is clear.
- R3: With mode 2'b00, V above +32767 gives 0x7FFF. This case is flagged when the high slice is positive, or is zero while the middle slice's bit 15 is set.
- R4: With mode 2'b01 (unsigned middle), V above +32767 gives 0xFFFF.
- R5: With mode 2'b01, a negative V (in range or below -32768) gives 0x0000, and a V in 0..+32767 gives the middle slice.
- R6: With mode 2'b10 (signed low), when the signed-middle value of R1 to R3 equals the raw middle slice, the result is the low slice (bits 15:0).
- R7: With mode 2'b10, when that saturated value differs from the middle slice, the result is the saturated value XOR 0x8000: 0x0000 for underflow and 0xFFFF for overflow.
- R8: With mode 2'b10, an underflow whose middle slice is 0x8000, or an overflow whose middle slice is 0x7FFF, still passes the low slice, because the two values compare equal.
- R9: Mode 2'b11 behaves exactly as mode 2'b00.
- R10: Lane k uses bits 16k+15:16k of every bus, and its result depends only on its own slices and the shared mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_hi | input | 128 | High slices (accumulator bits 47:32), lane k at bits 16k+15:16k |
| acc_mid | input | 128 | Middle slices (accumulator bits 31:16), packed as above |
| acc_lo | input | 128 | Low slices (accumulator bits 15:0), packed as above |
| mode | input | 2 | 00 signed middle, 01 unsigned middle, 10 signed low, 11 as 00 |
| result | output | 128 | Narrowed 16-bit result for each lane, packed as above |

## Verification
The assertions watch every lane on every input change. They check that the underflow and overflow flags never fire together, that each flag agrees with the sign of the high slice, and that the result takes the fixed saturation code or the passed slice that the mode and flags demand. Only the bench's scenarios show that the flags are raised at exactly the right 48-bit boundaries, that the equality corner of the low mode passes the low slice, and that lanes do not leak into each other. It does this by comparing every lane against a model written in plain 48-bit signed arithmetic, over directed boundary values and a pseudo-random sweep.

// File: rtl/acc_clamp_pkg.sv
package acc_clamp_pkg;
  typedef enum logic [1:0] {
    CLAMP_SMID = 2'b00,
    CLAMP_UMID = 2'b01,
    CLAMP_SLOW = 2'b10,
    CLAMP_RSVD = 2'b11
  } clamp_mode_e;
endpackage

// File: rtl/acr_range_detect.sv
module acr_range_detect #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] hi,
  input  logic          mid_msb,
  output logic          under,
  output logic          over
);
  // high slice below minus one: negative and not all ones
  function automatic logic below_minus_one(input logic [SW-1:0] h);
    return h[SW-1] & ~(&h);
  endfunction

  // high slice strictly positive
  function automatic logic strictly_pos(input logic [SW-1:0] h);
    return ~h[SW-1] & (|h);
  endfunction

  always_comb begin
    under = below_minus_one(hi) | (hi[SW-1] & ~mid_msb);
    over  = strictly_pos(hi) | (~(|hi) & mid_msb);
  end
endmodule

// File: rtl/acr_lane_select.sv
module acr_lane_select
  import acc_clamp_pkg::*;
#(
  parameter int SW = 16
) (
  input  clamp_mode_e   mode,
  input  logic [SW-1:0] mid,
  input  logic [SW-1:0] low,
  input  logic          under,
  input  logic          over,
  output logic [SW-1:0] res
);
  localparam logic [SW-1:0] MIN_NEG = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MAX_POS = ~MIN_NEG;

  logic [SW-1:0] sat;

  function automatic logic [SW-1:0] sat_signed(input logic u, input logic o,
                                               input logic [SW-1:0] m);
    if (u)      return MIN_NEG;
    else if (o) return MAX_POS;
    else        return m;
  endfunction

  always_comb begin
    sat = sat_signed(under, over, mid);
    unique case (mode)
      CLAMP_UMID: begin
        if (over)              res = '1;
        else if (sat[SW-1])    res = '0;
        else                   res = sat;
      end
      CLAMP_SLOW: begin
        if (sat == mid)        res = low;
        else                   res = sat ^ MIN_NEG;
      end
      default:                 res = sat;
    endcase
  end
endmodule

// File: rtl/accum_clamp_array.sv
module accum_clamp_array
  import acc_clamp_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int SLICE_W = 16
) (
  input  logic [LANES*SLICE_W-1:0] acc_hi,
  input  logic [LANES*SLICE_W-1:0] acc_mid,
  input  logic [LANES*SLICE_W-1:0] acc_lo,
  input  logic [1:0]               mode,
  output logic [LANES*SLICE_W-1:0] result
);
  logic [LANES-1:0] lane_under;
  logic [LANES-1:0] lane_over;
  clamp_mode_e      mode_e;

  assign mode_e = clamp_mode_e'(mode);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    acr_range_detect #(.SW(SLICE_W)) u_det (
      .hi      (acc_hi[k*SLICE_W +: SLICE_W]),
      .mid_msb (acc_mid[k*SLICE_W + SLICE_W - 1]),
      .under   (lane_under[k]),
      .over    (lane_over[k])
    );
    acr_lane_select #(.SW(SLICE_W)) u_sel (
      .mode  (mode_e),
      .mid   (acc_mid[k*SLICE_W +: SLICE_W]),
      .low   (acc_lo[k*SLICE_W +: SLICE_W]),
      .under (lane_under[k]),
      .over  (lane_over[k]),
      .res   (result[k*SLICE_W +: SLICE_W])
    );
  end
endmodule

// File: rtl/accum_clamp_chk.sv
module accum_clamp_chk #(
  parameter int LANES = 8,
  parameter int SW    = 16
) (
  input logic [LANES*SW-1:0] acc_hi,
  input logic [LANES*SW-1:0] acc_mid,
  input logic [LANES*SW-1:0] acc_lo,
  input logic [1:0]          mode,
  input logic [LANES*SW-1:0] result,
  input logic [LANES-1:0]    lane_under,
  input logic [LANES-1:0]    lane_over
);
  localparam logic [SW-1:0] MIN_NEG = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MAX_POS = ~MIN_NEG;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      // R2
      if (lane_under[k]) begin
        no_dual_flag_chk: assert (!lane_over[k] && acc_hi[k*SW+SW-1]);
      end
      // R3
      if (lane_over[k]) begin
        over_sign_chk: assert (!acc_hi[k*SW+SW-1]);
      end
      // R1
      if ((mode == 2'b00 || mode == 2'b11) && lane_under[k] == 1'b0 && lane_over[k] == 1'b0) begin
        mid_pass_chk: assert (result[k*SW +: SW] == acc_mid[k*SW +: SW]);
      end
      // R2
      if (mode == 2'b00 && lane_under[k] == 1'b1) begin
        sat_low_chk: assert (result[k*SW +: SW] == MIN_NEG);
      end
      // R3
      if (mode == 2'b00 && lane_over[k] == 1'b1) begin
        sat_high_chk: assert (result[k*SW +: SW] == MAX_POS);
      end
      // R4
      if (mode == 2'b01 && lane_over[k] == 1'b1) begin
        uns_over_chk: assert (result[k*SW +: SW] == '1);
      end
      // R6
      if (mode == 2'b10 && lane_under[k] == 1'b0 && lane_over[k] == 1'b0) begin
        low_pass_chk: assert (result[k*SW +: SW] == acc_lo[k*SW +: SW]);
      end
      // R7
      if (mode == 2'b10 && lane_under[k] == 1'b1 && acc_mid[k*SW +: SW] != MIN_NEG) begin
        low_under_chk: assert (result[k*SW +: SW] == '0);
      end
    end
  end
endmodule

bind accum_clamp_array accum_clamp_chk #(.LANES(LANES), .SW(SLICE_W)) u_chk (
  .acc_hi     (acc_hi),
  .acc_mid    (acc_mid),
  .acc_lo     (acc_lo),
  .mode       (mode),
  .result     (result),
  .lane_under (lane_under),
  .lane_over  (lane_over)
);

// File: tb/test_accum_clamp_array.sv
`timescale 1ns/1ps
module test_accum_clamp_array;
  localparam int LN = 8;
  localparam int W  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [LN*W-1:0] acc_hi, acc_mid, acc_lo, result;
  logic [1:0]      mode;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  accum_clamp_array i_accum_clamp_array (
    .acc_hi(acc_hi), .acc_mid(acc_mid), .acc_lo(acc_lo),
    .mode(mode), .result(result)
  );

  // model from plain 48-bit signed arithmetic
  function automatic logic [15:0] model(input logic [1:0] md, input logic [47:0] a);
    logic signed [31:0] v;
    logic [15:0] clamped;
    v = $signed(a[47:16]);
    if (v < -32768)      clamped = 16'h8000;
    else if (v > 32767)  clamped = 16'h7FFF;
    else                 clamped = a[31:16];
    case (md)
      2'b01:   return (v > 32767) ? 16'hFFFF : (v < 0 ? 16'h0000 : clamped);
      2'b10:   return (clamped == a[31:16]) ? a[15:0] : {~clamped[15], clamped[14:0]};
      default: return clamped;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  logic [47:0] acc [LN];

  task automatic apply(input logic [1:0] md);
    @(negedge clk);
    mode = md;
    for (int k = 0; k < LN; k++) begin
      acc_hi[k*W +: W]  = acc[k][47:32];
      acc_mid[k*W +: W] = acc[k][31:16];
      acc_lo[k*W +: W]  = acc[k][15:0];
    end
    #1;
  endtask

  task automatic verify_all(input string tag, input logic [1:0] md);
    for (int k = 0; k < LN; k++) chk(tag, result[k*W +: W], model(md, acc[k]));
  endtask

  task automatic fill(input logic [47:0] a);
    for (int k = 0; k < LN; k++) acc[k] = a;
  endtask

  task automatic t_zero;
    fill(48'h0); apply(2'b00);
    chk("R1 zero", result[15:0], 16'h0000);
    verify_all("R1 zero", 2'b00);
  endtask

  task automatic t_signed_range;
    acc[0] = 48'h0000_7FFF_1111; acc[1] = 48'hFFFF_8000_2222;
    acc[2] = 48'h0000_1234_0000; acc[3] = 48'hFFFF_FFFF_FFFF;
    acc[4] = 48'h0000_0000_ABCD; acc[5] = 48'hFFFF_C000_0001;
    acc[6] = 48'h0000_0001_0000; acc[7] = 48'hFFFF_8001_0000;
    apply(2'b00);
    chk("R1 max edge", result[15:0], 16'h7FFF);
    chk("R1 min edge", result[31:16], 16'h8000);
    verify_all("R1", 2'b00);
  endtask

  task automatic t_signed_under;
    acc[0] = 48'hFFFF_7FFF_0000; acc[1] = 48'hFFFE_8000_0000;
    acc[2] = 48'h8000_0000_0000; acc[3] = 48'hFFFE_FFFF_FFFF;
    acc[4] = 48'hFFFF_0000_1234; acc[5] = 48'hF000_1234_0000;
    acc[6] = 48'hFFFF_7000_0000; acc[7] = 48'h8000_8000_8000;
    apply(2'b00);
    chk("R2 just below", result[15:0], 16'h8000);
    verify_all("R2", 2'b00);
  endtask

  task automatic t_signed_over;
    acc[0] = 48'h0000_8000_0000; acc[1] = 48'h0001_0000_0000;
    acc[2] = 48'h7FFF_FFFF_FFFF; acc[3] = 48'h0001_7FFF_0000;
    acc[4] = 48'h0000_FFFF_0000; acc[5] = 48'h0100_1234_5678;
    acc[6] = 48'h0000_8001_0000; acc[7] = 48'h7FFF_0000_0000;
    apply(2'b00);
    chk("R3 just above", result[15:0], 16'h7FFF);
    verify_all("R3", 2'b00);
  endtask

  task automatic t_unsigned;
    acc[0] = 48'h0000_8000_0000; acc[1] = 48'h0001_7FFF_0000;
    acc[2] = 48'hFFFF_FFFF_0000; acc[3] = 48'hFFFE_0000_0000;
    acc[4] = 48'h0000_7FFF_0000; acc[5] = 48'h0000_0000_FFFF;
    acc[6] = 48'hFFFF_8000_0000; acc[7] = 48'h0000_1234_0000;
    apply(2'b01);
    chk("R4 over", result[15:0], 16'hFFFF);
    chk("R4 over mid 7fff", result[31:16], 16'hFFFF);
    chk("R5 negative", result[47:32], 16'h0000);
    chk("R5 under", result[63:48], 16'h0000);
    chk("R5 positive", result[127:112], 16'h1234);
    verify_all("R5", 2'b01);
  endtask

  task automatic t_low;
    acc[0] = 48'h0000_1234_5678; acc[1] = 48'hFFFF_FFFF_9ABC;
    acc[2] = 48'hFFFF_7FFF_1111; acc[3] = 48'h0000_8000_2222;
    acc[4] = 48'hFFFE_0000_3333; acc[5] = 48'h0001_0000_4444;
    acc[6] = 48'h0000_7FFF_FFFF; acc[7] = 48'hFFFF_8000_0000;
    apply(2'b10);
    chk("R6 pass", result[15:0], 16'h5678);
    chk("R6 pass neg", result[31:16], 16'h9ABC);
    chk("R7 under", result[47:32], 16'h0000);
    chk("R7 over", result[63:48], 16'hFFFF);
    verify_all("R7", 2'b10);
  endtask

  task automatic t_low_corner;
    acc[0] = 48'hFFFE_8000_1357; acc[1] = 48'h0001_7FFF_2468;
    acc[2] = 48'h8000_8000_0F0F; acc[3] = 48'h7FFF_7FFF_F0F0;
    acc[4] = 48'hFFFE_8001_0000; acc[5] = 48'h0001_7FFE_0000;
    acc[6] = 48'hFFFE_8000_0000; acc[7] = 48'h0001_7FFF_FFFF;
    apply(2'b10);
    chk("R8 under eq", result[15:0], 16'h1357);
    chk("R8 over eq", result[31:16], 16'h2468);
    chk("R8 under ne", result[79:64], 16'h0000);
    chk("R8 over ne", result[95:80], 16'hFFFF);
    verify_all("R8", 2'b10);
  endtask

  task automatic t_reserved;
    acc[0] = 48'h0000_8000_0000; acc[1] = 48'hFFFE_0000_0000;
    acc[2] = 48'h0000_4321_AAAA; acc[3] = 48'hFFFF_9000_5555;
    acc[4] = 48'h0100_0000_0000; acc[5] = 48'hFFFF_7FFF_0000;
    acc[6] = 48'h0000_0000_0000; acc[7] = 48'h0000_7FFF_FFFF;
    apply(2'b11);
    chk("R9 over", result[15:0], 16'h7FFF);
    chk("R9 under", result[31:16], 16'h8000);
    chk("R9 pass", result[47:32], 16'h4321);
    verify_all("R9", 2'b00);
  endtask

  task automatic t_lanes;
    logic [31:0] s = 32'h1ACE_B00C;
    for (int k = 0; k < LN; k++) acc[k] = {16'h0000, 16'(k * 16'h1111 + 1), 16'hFFFF};
    apply(2'b00);
    for (int k = 0; k < LN; k++) chk("R10 placement", result[k*W +: W], 16'(k * 16'h1111 + 1));
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < LN; k++) begin
        logic [47:0] a;
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        a[47:32] = (s[2:0] == 3'd0) ? 16'h0000 : (s[2:0] == 3'd1) ? 16'hFFFF :
                   (s[2:0] == 3'd2) ? 16'h0001 : (s[2:0] == 3'd3) ? 16'hFFFE : s[31:16];
        a[31:16] = s[3] ? {s[4], {15{s[5]}}} : s[27:12];
        a[15:0]  = s[15:0] ^ s[31:16];
        acc[k] = a;
      end
      apply(2'(n));
      verify_all("R10 sweep", 2'(n));
    end
  endtask

  initial begin
    acc_hi = '0; acc_mid = '0; acc_lo = '0; mode = 2'b00;
    repeat (2) @(posedge clk);
    t_zero();
    t_signed_range();
    t_signed_under();
    t_signed_over();
    t_unsigned();
    t_low();
    t_low_corner();
    t_reserved();
    t_lanes();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule